// File: doc/BRIEF.md
# Carrier Interrupt Status Controller

This block gathers interrupt requests from four plug-in module slots, each with two request lines, and folds them into a single interrupt output toward the host. Every request line has its own control bits: an enable that decides whether the line is tracked at all, and a sensitivity select. A level line adds to a held output level. An edge line, on a rising change, makes the output take the opposite of its held value for one clock.

Software reaches the block through a small register file of 16-bit words. It holds a revision word, one control byte per slot, an inert reset word and a status word. The status word shows the tracked request lines, four timeout flags and four error flags. Writing ones to the status word sends one-cycle clear strobes to the installed modules for the chosen requests. The same write clears the chosen timeout flags.

Top module: `carrier_irq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every control byte, the status word, the interrupt output and all clear strobes read zero.
- R2: When request n of slot s is enabled (control bit 6+n set), status bit 2*s+n takes the level of that request line on the next clock edge. Status reads at byte offset 0x0C.
- R3: While a request's enable bit is clear, changes on that line leave both its status bit and the interrupt output unchanged.
- R4: An edge-sensitive request (control bit 4+n set) whose status bit goes from 0 to 1 inverts the interrupt output for exactly one cycle, starting one cycle after the line rises. A 1-to-0 change makes no pulse.
- R5: When a level-sensitive status bit changes, the held output is set to the OR of all status bits whose edge select is clear. This takes effect one cycle after the line change.
- R6: If an edge rise and a level change happen in the same cycle, the level change sets the new held value and the one-cycle pulse inverts that new value.
- R7: The control byte of slot s reads and writes at byte offset 0x02+2*s in bits 7:0, and bits 15:8 read 0. Revision (0x00) and reset (0x0A) read 0 and ignore writes. Every other offset reads 0.
- R8: Writing a 1 to status bit 2*s+n raises clear strobe 2*s+n for one cycle after the write edge, but only if slot s is marked present.
- R9: A pulse on timeout input s sets status bit 12+s. Writing 1 to that bit clears it. A set and a clear in the same cycle leave the flag set.
- R10: Status bits 8 to 11 read 0, and writes to them have no effect on any status bit.
- R11: A status write never changes the request bits of the status word directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Request lines, bit 2*slot+n |
| timeout_i | input | 4 | Timeout event per slot, sets flag |
| present_i | input | 4 | Slot has an installed module |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe for the addressed word |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| clr_o | output | 8 | One-cycle request clear strobes |
| irq_o | output | 1 | Interrupt output toward the host |

## Verification
The bench raises an edge request and a level request in the same cycle. A design that let the edge win would leave the output wrong in both cycles of the pulse. It pulses an edge line while the held level is high and checks for a low dip, not a high glitch. It drops an edge line and checks that no pulse follows. It toggles disabled lines and checks that neither status nor output moves, which a design ignoring the enable would fail. Clear strobes go to a partly populated carrier, where a strobe to an empty slot would show. Timeout flags are set and cleared in the same cycle, where a design with clear priority would lose the flag.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;
  localparam int REQ_PER_SLOT  = 2;
  localparam int WORD_W        = 16;
  localparam int CTRL_W        = 8;
  localparam int CTRL_EDGE_LSB = 4;
  localparam int CTRL_EN_LSB   = 6;
  localparam int ERR_LSB       = 8;
  localparam int ERR_W         = 4;
  localparam int TMO_LSB       = 12;

  localparam logic [7:0] OFS_REV   = 8'h00;
  localparam logic [7:0] OFS_CTRL0 = 8'h02;
  localparam logic [7:0] OFS_RST   = 8'h0A;
  localparam logic [7:0] OFS_STAT  = 8'h0C;

  // status bit position of request n of a slot
  function automatic int line_idx(int slot, int n);
    return slot * REQ_PER_SLOT + n;
  endfunction

  // byte offset of a slot's control word
  function automatic logic [7:0] ctrl_ofs(int slot);
    return 8'(int'(OFS_CTRL0) + 2 * slot);
  endfunction

  // next tracked value of one request line
  function automatic logic track_next(logic en, logic req, logic cur);
    return en ? req : cur;
  endfunction
endpackage

// File: rtl/irq_line_track.sv
module irq_line_track
  import carrier_irq_pkg::*;
#(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] req_i,
  input  logic [NLINES-1:0] en_i,
  input  logic [NLINES-1:0] edge_i,
  output logic [NLINES-1:0] status_o,
  output logic              edge_rise_o,
  output logic              level_chg_o,
  output logic              level_any_o
);
  logic [NLINES-1:0] status_q;
  logic [NLINES-1:0] nxt;
  logic [NLINES-1:0] chg;
  logic [NLINES-1:0] rise_edge;
  logic [NLINES-1:0] chg_level;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    assign nxt[i]       = track_next(en_i[i], req_i[i], status_q[i]);
    assign chg[i]       = nxt[i] ^ status_q[i];
    assign rise_edge[i] = chg[i] & nxt[i] & edge_i[i];
    assign chg_level[i] = chg[i] & ~edge_i[i];

    always_ff @(posedge clk) begin
      if (rst) status_q[i] <= 1'b0;
      else     status_q[i] <= nxt[i];
    end

    // R2
    follow_chk: assert property (@(posedge clk) disable iff (rst)
      en_i[i] |=> status_q[i] == $past(req_i[i]));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en_i[i] |=> $stable(status_q[i]));
  end

  assign edge_rise_o = |rise_edge;
  assign level_chg_o = |chg_level;
  assign level_any_o = |(nxt & ~edge_i);
  assign status_o    = status_q;
endmodule

// File: rtl/irq_host_out.sv
module irq_host_out (
  input  logic clk,
  input  logic rst,
  input  logic edge_rise_i,
  input  logic level_chg_i,
  input  logic level_any_i,
  output logic irq_o
);
  logic held_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (level_chg_i) held_q <= level_any_i;
      pulse_q <= edge_rise_i;
    end
  end

  assign irq_o = held_q ^ pulse_q;

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(irq_o) |-> $past(edge_rise_i || level_chg_i || pulse_q));
  // R6
  both_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_rise_i && level_chg_i) |=> irq_o == !$past(level_any_i));
  // R5
  level_only_chk: assert property (@(posedge clk) disable iff (rst)
    (level_chg_i && !edge_rise_i) |=> irq_o == $past(level_any_i));
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import carrier_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 8,
  localparam int NLINES   = NUM_SLOTS * REQ_PER_SLOT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [NLINES-1:0] req_status_i,
  input  logic [NUM_SLOTS-1:0] timeout_i,
  input  logic [NUM_SLOTS-1:0] present_i,
  output logic [NLINES-1:0] en_o,
  output logic [NLINES-1:0] edge_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic [NLINES-1:0] clr_o
);
  logic [CTRL_W-1:0]    ctrl_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] to_q;
  logic [NLINES-1:0]    clr_q;
  logic [WORD_W-1:0]    status_word;
  logic                 stat_wr;
  logic                 err_touch;

  assign stat_wr   = wr_i && (addr_i == ADDR_W'(OFS_STAT));
  assign err_touch = stat_wr && (|wdata_i[ERR_LSB +: ERR_W]);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) ctrl_q[s] <= '0;
      else if (wr_i && addr_i == ADDR_W'(ctrl_ofs(s))) ctrl_q[s] <= wdata_i[CTRL_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)                                     to_q[s] <= 1'b0;
      else if (timeout_i[s])                       to_q[s] <= 1'b1;
      else if (stat_wr && wdata_i[TMO_LSB + s])    to_q[s] <= 1'b0;
    end

    for (genvar n = 0; n < REQ_PER_SLOT; n++) begin : g_req
      localparam int L = s * REQ_PER_SLOT + n;
      assign en_o[L]   = ctrl_q[s][CTRL_EN_LSB + n];
      assign edge_o[L] = ctrl_q[s][CTRL_EDGE_LSB + n];

      always_ff @(posedge clk) begin
        if (rst) clr_q[L] <= 1'b0;
        else     clr_q[L] <= stat_wr && wdata_i[L] && present_i[s];
      end

      // R8
      strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        clr_q[L] |-> $past(stat_wr && wdata_i[L] && present_i[s]));
    end

    // R9
    tmo_set_chk: assert property (@(posedge clk) disable iff (rst)
      timeout_i[s] |=> to_q[s]);
    // R9
    tmo_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (stat_wr && wdata_i[TMO_LSB + s] && !timeout_i[s]) |=> !to_q[s]);
  end

  always_comb begin
    status_word = '0;
    status_word[NLINES-1:0] = req_status_i;
    status_word[TMO_LSB +: NUM_SLOTS] = to_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_STAT)) rdata_o = status_word;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (addr_i == ADDR_W'(ctrl_ofs(s))) rdata_o = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q[s]};
    end
  end

  assign clr_o = clr_q;

  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    err_touch |=> status_word[ERR_LSB +: ERR_W] == '0);
  // R7
  rev_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i == ADDR_W'(OFS_REV) || addr_i == ADDR_W'(OFS_RST)) |-> rdata_o == '0);
endmodule

// File: rtl/carrier_irq_ctrl.sv
module carrier_irq_ctrl
  import carrier_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 8,
  localparam int NLINES   = NUM_SLOTS * REQ_PER_SLOT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NLINES-1:0]    req_i,
  input  logic [NUM_SLOTS-1:0] timeout_i,
  input  logic [NUM_SLOTS-1:0] present_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic [NLINES-1:0]    clr_o,
  output logic                 irq_o
);
  logic [NLINES-1:0] line_en;
  logic [NLINES-1:0] line_edge;
  logic [NLINES-1:0] line_status;
  logic              edge_rise;
  logic              level_chg;
  logic              level_any;

  irq_regfile #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .req_status_i(line_status), .timeout_i(timeout_i), .present_i(present_i),
    .en_o(line_en), .edge_o(line_edge), .rdata_o(rdata_o), .clr_o(clr_o)
  );

  irq_line_track #(.NLINES(NLINES)) u_track (
    .clk(clk), .rst(rst), .req_i(req_i), .en_i(line_en), .edge_i(line_edge),
    .status_o(line_status), .edge_rise_o(edge_rise), .level_chg_o(level_chg),
    .level_any_o(level_any)
  );

  irq_host_out u_out (
    .clk(clk), .rst(rst), .edge_rise_i(edge_rise), .level_chg_i(level_chg),
    .level_any_i(level_any), .irq_o(irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq_o && clr_o == '0 && line_status == '0));
endmodule

// File: tb/carrier_irq_ctrl_test.sv
module carrier_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req = '0;
  logic [3:0]  timeout = '0;
  logic [3:0]  present = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  clr;
  logic        irq;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  carrier_irq_ctrl uut (
    .clk(clk), .rst(rst), .req_i(req), .timeout_i(timeout), .present_i(present),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .clr_o(clr), .irq_o(irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  // drive req at a negedge, return at the negedge after the capture edge
  task automatic set_req(logic [7:0] v);
    @(negedge clk);
    req = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 clr", {8'd0, clr}, 16'd0);
    rd(8'h0C, 16'h0000, "R1 status");
    rd(8'h02, 16'h0000, "R1 ctrl A");
  endtask

  task automatic t_regmap;
    wr_reg(8'h02, 16'hABC1);
    rd(8'h02, 16'h00C1, "R7 ctrl A low byte");
    wr_reg(8'h08, 16'h00F0);
    rd(8'h08, 16'h00F0, "R7 ctrl D");
    wr_reg(8'h00, 16'hFFFF);
    rd(8'h00, 16'h0000, "R7 revision");
    wr_reg(8'h0A, 16'hFFFF);
    rd(8'h0A, 16'h0000, "R7 reset word");
    rd(8'h0E, 16'h0000, "R7 unused 0x0E");
    rd(8'h40, 16'h0000, "R7 unused 0x40");
    rd(8'h04, 16'h0000, "R7 ctrl B untouched");
    wr_reg(8'h02, 16'h0000);
    wr_reg(8'h08, 16'h0000);
  endtask

  task automatic t_disabled;
    set_req(8'hFF);
    chk("R3 irq", {15'd0, irq}, 16'd0);
    rd(8'h0C, 16'h0000, "R3 status");
    set_req(8'h00);
    chk("R3 irq after drop", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_level;
    wr_reg(8'h02, 16'h00C0);
    set_req(8'h02);
    chk("R5 irq on A1", {15'd0, irq}, 16'd1);
    rd(8'h0C, 16'h0002, "R2 status A1");
    set_req(8'h03);
    rd(8'h0C, 16'h0003, "R2 status A0 A1");
    set_req(8'h01);
    chk("R5 irq held with A0", {15'd0, irq}, 16'd1);
    set_req(8'h00);
    chk("R5 irq low", {15'd0, irq}, 16'd0);
    wr_reg(8'h06, 16'h0040);
    set_req(8'h10);
    chk("R5 irq C0", {15'd0, irq}, 16'd1);
    rd(8'h0C, 16'h0010, "R2 status C0");
    set_req(8'h00);
    chk("R5 irq C0 low", {15'd0, irq}, 16'd0);
    wr_reg(8'h02, 16'h0000);
    wr_reg(8'h06, 16'h0000);
  endtask

  task automatic t_edge;
    wr_reg(8'h04, 16'h0050);
    set_req(8'h04);
    chk("R4 pulse high", {15'd0, irq}, 16'd1);
    @(negedge clk);
    chk("R4 pulse end", {15'd0, irq}, 16'd0);
    rd(8'h0C, 16'h0004, "R2 status B0");
    set_req(8'h00);
    chk("R4 no pulse on fall", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R4 no pulse on fall 2", {15'd0, irq}, 16'd0);
    wr_reg(8'h02, 16'h0040);
    set_req(8'h01);
    chk("R5 held high", {15'd0, irq}, 16'd1);
    set_req(8'h05);
    chk("R4 dip low", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R4 dip end", {15'd0, irq}, 16'd1);
    set_req(8'h00);
    chk("R5 held low", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_combined;
    // ctrl A level on A0, ctrl B edge on B0 remain from t_edge
    set_req(8'h05);
    chk("R6 inverted new level", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R6 settles high", {15'd0, irq}, 16'd1);
    set_req(8'h00);
    chk("R6 low after drop", {15'd0, irq}, 16'd0);
    wr_reg(8'h04, 16'h0000);
  endtask

  task automatic t_clear;
    present = 4'b0101;
    set_req(8'h01);
    wr_reg(8'h0C, 16'h00FF);
    chk("R8 strobes present only", {8'd0, clr}, 16'h0033);
    @(negedge clk);
    chk("R8 strobe one cycle", {8'd0, clr}, 16'h0000);
    rd(8'h0C, 16'h0001, "R11 request bit kept");
    set_req(8'h00);
    wr_reg(8'h02, 16'h0000);
  endtask

  task automatic t_timeout;
    @(negedge clk);
    timeout = 4'b0010;
    @(negedge clk);
    timeout = 4'b0000;
    rd(8'h0C, 16'h2000, "R9 flag B set");
    wr_reg(8'h0C, 16'h2000);
    rd(8'h0C, 16'h0000, "R9 flag B cleared");
    @(negedge clk);
    timeout = 4'b1000; addr = 8'h0C; wdata = 16'h8000; wr = 1'b1;
    @(negedge clk);
    timeout = 4'b0000; wr = 1'b0; wdata = '0;
    rd(8'h0C, 16'h8000, "R9 set beats clear");
    wr_reg(8'h0C, 16'h0F00);
    rd(8'h0C, 16'h8000, "R10 error write no effect");
    wr_reg(8'h0C, 16'h8000);
    rd(8'h0C, 16'h0000, "R9 flag D cleared");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_disabled();
    t_level();
    t_edge();
    t_combined();
    t_clear();
    t_timeout();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule